// File: doc/BRIEF.md
# Ethernet Transmit Pad and FCS Inserter

This block sits on the transmit path of an Ethernet MAC, between the client and the framing logic that adds preamble and inter-packet gap. Client frames arrive as a byte stream starting at the destination address. A start marker flags the first byte and an end marker flags the last. Every client byte passes straight through on the same cycle. When the client frame is shorter than the minimum, zero bytes are appended after it. A 32-bit frame check sequence, computed over every byte sent including the pad, is then appended.

The `fcs_en` control pin selects per frame whether the check sequence is generated. The pin is meant to be driven by a configuration bit whose reset value is 1. When it is low, the client is expected to supply its own check sequence inside its data. Short frames are then padded to the full 64-byte minimum with no CRC added.

Both sides use valid/ready handshakes. A byte moves on a cycle where valid and ready are both high. While client bytes flow, `in_ready` mirrors `out_ready`, so downstream back-pressure reaches the client with no added latency. While pad or check bytes are being emitted, `in_ready` is held low. An appended byte, once presented, stays on `out_data` until it is taken. The client must keep `in_valid` and its data stable until accepted, and must mark the first byte of each frame with `in_sof`.

Top module: `txpf_inserter`

## Requirements
- R1: While no appended byte is pending, `out_valid`, `out_data`, `out_sof` equal `in_valid`, `in_data`, `in_sof` in the same cycle. `in_ready` equals `out_ready`. Each client byte is forwarded unchanged and exactly once.
- R2: The two-byte length/type field (frame bytes 12 and 13) is forwarded unmodified. This holds whether it holds a type (0x0600 and above) or a payload length (0 to 1500).
- R3: With the check sequence enabled, a client frame of N < 60 bytes is followed by 60-N bytes of 0x00 and then the 4 check bytes, for 64 bytes in total.
- R4: With the check sequence enabled, a client frame of 60 bytes or more gets no pad. It is followed directly by the 4 check bytes.
- R5: The check value is the reflected CRC-32 with generator x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1. The register is preset to all ones and the result is complemented. It covers every client and pad byte. It is appended least significant byte first, with each byte's bit 0 carrying the highest-order (x^31) coefficient, so the x^32 side goes out first on a serial line.
- R6: With the check sequence disabled, a client frame of N < 64 bytes is followed by 64-N bytes of 0x00. Frames of 64 bytes or more are passed unchanged. No check bytes are ever added.
- R7: `in_ready` is low while pad or check bytes are emitted. `out_eof` is asserted on exactly one byte per frame: the last appended byte if any, otherwise the last client byte.
- R8: `fcs_en` is sampled when the start-of-frame byte is accepted. A change of `fcs_en` later in the same frame has no effect on that frame.
- R9: While `out_ready` is low during appended bytes, `out_valid` stays high and `out_data` and `out_eof` stay unchanged.
- R10: After reset (`rst_n` low) no appended byte is pending. With `in_valid` low, `out_valid` is low and `in_ready` follows `out_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fcs_en | input | 1 | 1 = append CRC-32, 0 = client supplies its own check sequence |
| in_valid | input | 1 | Client byte valid |
| in_ready | output | 1 | Block accepts client byte |
| in_data | input | 8 | Client byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last client byte of frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |

## Verification
The bench targets the padding boundaries: a one-byte frame, and frames one short of, exactly at and above the 60-byte and 64-byte thresholds in each mode. An off-by-one pad counter there would produce a frame of 63 or 65 bytes. It checks the CRC against a separately formulated non-reflected reference. A wrong byte order, a missing final inversion or pad bytes left out of the CRC would all show as a mismatch. It toggles `fcs_en` mid-frame, which would expose a design that reads the pin at end of frame. It stalls `out_ready` pseudo-randomly during appended bytes, where a design that lets the client through or advances under stall would lose or duplicate bytes.

// File: rtl/txpf_pkg.sv
package txpf_pkg;
  typedef enum logic [1:0] {
    ST_PASS = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } txpf_state_e;

  // reflected form of the Ethernet CRC-32 generator
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
endpackage

// File: rtl/txpf_crc.sv
module txpf_crc #(
  parameter int          CRC_W  = 32,
  parameter int          BYTE_W = 8,
  parameter logic [31:0] POLY   = txpf_pkg::CRC_POLY_REFL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed,   // first byte of frame: start from all ones
  input  logic              step,   // absorb din this cycle
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  fcs     // complemented running value
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] chain [0:BYTE_W];

  assign chain[0] = seed ? {CRC_W{1'b1}} : crc_q;

  // one LSB-first shift stage per input bit
  for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
    logic fb;
    assign fb = chain[g][0] ^ din[g];
    assign chain[g+1] = fb ? ((chain[g] >> 1) ^ POLY[CRC_W-1:0]) : (chain[g] >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= {CRC_W{1'b1}};
    else if (step) crc_q <= chain[BYTE_W];
  end

  assign fcs = ~crc_q;
endmodule

// File: rtl/txpf_len.sv
module txpf_len #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,    // current byte is the first of a frame
  input  logic             step,     // current byte accepted
  output logic [CNT_W-1:0] len_next  // count including the current byte
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] len_q;

  always_comb begin
    if (start)               len_next = CNT_W'(1);
    else if (len_q == CNT_MAX) len_next = CNT_MAX;   // saturate past the minimum
    else                     len_next = len_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (step) len_q <= len_next;
  end
endmodule

// File: rtl/txpf_tail.sv
module txpf_tail
  import txpf_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int FCS_BYTES = 4,
  localparam int IDX_W    = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,        // last client byte accepted
  input  logic [CNT_W-1:0] pad_need,  // zero bytes to add after it
  input  logic             fcs_on,    // add check bytes after the pad
  input  logic             fire,      // output handshake
  output txpf_state_e      st,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_BYTES - 1);

  txpf_state_e      st_q, st_d;
  logic [CNT_W-1:0] pad_q, pad_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             fcs_q, fcs_d;

  always_comb begin
    st_d  = st_q;
    pad_d = pad_q;
    idx_d = idx_q;
    fcs_d = fcs_q;
    unique case (st_q)
      ST_PASS: begin
        if (go) begin
          fcs_d = fcs_on;
          idx_d = '0;
          pad_d = pad_need;
          if (pad_need != '0) st_d = ST_PAD;
          else if (fcs_on)    st_d = ST_FCS;
        end
      end
      ST_PAD: begin
        if (fire) begin
          pad_d = pad_q - CNT_W'(1);
          if (pad_q == CNT_W'(1)) st_d = fcs_q ? ST_FCS : ST_PASS;
        end
      end
      ST_FCS: begin
        if (fire) begin
          if (idx_q == IDX_LAST) begin
            st_d  = ST_PASS;
            idx_d = '0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      default: st_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PASS;
      pad_q <= '0;
      idx_q <= '0;
      fcs_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      pad_q <= pad_d;
      idx_q <= idx_d;
      fcs_q <= fcs_d;
    end
  end

  assign st   = st_q;
  assign idx  = idx_q;
  assign last = ((st_q == ST_PAD) && (pad_q == CNT_W'(1)) && !fcs_q) ||
                ((st_q == ST_FCS) && (idx_q == IDX_LAST));
endmodule

// File: rtl/txpf_inserter.sv
module txpf_inserter
  import txpf_pkg::*;
#(
  parameter int MIN_FRAME = 64,
  parameter int FCS_BYTES = 4,
  localparam int BYTE_W   = 8,
  localparam int CRC_W    = FCS_BYTES * BYTE_W,
  localparam int CNT_W    = $clog2(MIN_FRAME) + 1,
  localparam int IDX_W    = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fcs_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof
);
  localparam logic [CNT_W-1:0] MIN_WITH_FCS = CNT_W'(MIN_FRAME - FCS_BYTES);
  localparam logic [CNT_W-1:0] MIN_NO_FCS   = CNT_W'(MIN_FRAME);

  txpf_state_e      st;
  logic [IDX_W-1:0] idx;
  logic             tail_last;
  logic             pass;
  logic             in_fire, out_fire;
  logic             en_q, en_now;
  logic [CNT_W-1:0] len_next, data_min, pad_need;
  logic [CRC_W-1:0] fcs_word;
  logic [BYTE_W-1:0] fcs_byte;
  logic             crc_seed, crc_step;

  assign pass     = (st == ST_PASS);
  assign in_ready = pass && out_ready;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  // frame-level capture of the enable at the start byte
  assign en_now = in_sof ? fcs_en : en_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 en_q <= 1'b1;
    else if (in_fire && in_sof) en_q <= fcs_en;
  end

  txpf_len #(.CNT_W(CNT_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (in_sof),
    .step     (in_fire),
    .len_next (len_next)
  );

  assign data_min = en_now ? MIN_WITH_FCS : MIN_NO_FCS;
  assign pad_need = (len_next < data_min) ? (data_min - len_next) : '0;

  txpf_tail #(.CNT_W(CNT_W), .FCS_BYTES(FCS_BYTES)) u_tail (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (in_fire && in_eof),
    .pad_need (pad_need),
    .fcs_on   (en_now),
    .fire     (out_fire),
    .st       (st),
    .idx      (idx),
    .last     (tail_last)
  );

  assign crc_seed = in_fire && in_sof;
  assign crc_step = in_fire || ((st == ST_PAD) && out_fire);

  txpf_crc #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .seed  (crc_seed),
    .step  (crc_step),
    .din   (pass ? in_data : '0),
    .fcs   (fcs_word)
  );

  // least significant byte of the complemented value goes first
  always_comb begin
    fcs_byte = '0;
    for (int k = 0; k < FCS_BYTES; k++) begin
      if (idx == IDX_W'(k)) fcs_byte = fcs_word[k*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    if (pass) begin
      out_valid = in_valid;
      out_data  = in_data;
      out_sof   = in_sof;
      out_eof   = in_eof && (pad_need == '0) && !en_now;
    end else begin
      out_valid = 1'b1;
      out_data  = (st == ST_PAD) ? '0 : fcs_byte;
      out_sof   = 1'b0;
      out_eof   = tail_last;
    end
  end
endmodule

// File: rtl/txpf_chk.sv
module txpf_chk
  import txpf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_data,
  input logic        in_sof,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_sof,
  input logic        out_eof,
  input txpf_state_e st,
  input logic        en_q
);
  // R1: an accepted client byte leaves in the same cycle, unchanged
  p_pass_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (out_valid && out_ready && out_data == in_data));

  // R1: start marker only comes from the client
  p_sof_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (in_valid && in_sof));

  // R3: pad bytes are zero and always offered
  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAD) |-> (out_valid && out_data == 8'h00));

  // R7: client is held off while appending
  p_ready_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_PASS) |-> !in_ready);

  // R7: the end marker on an appended byte closes the tail
  p_eof_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_PASS && out_valid && out_ready && out_eof) |=> (st == ST_PASS));

  // R8: captured enable cannot move during the tail
  p_en_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_PASS) |=> $stable(en_q) || (st == ST_PASS));

  // R9: appended byte held under back-pressure
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_PASS && out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_eof)));
endmodule

bind txpf_inserter txpf_chk u_txpf_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_sof    (in_sof),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sof   (out_sof),
  .out_eof   (out_eof),
  .st        (st),
  .en_q      (en_q)
);

// File: tb/test_txpf_inserter.sv
module test_txpf_inserter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fcs_en = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_sof;
  logic       out_eof;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;  // 250 MHz

  txpf_inserter i_txpf_inserter (
    .clk(clk), .rst_n(rst_n), .fcs_en(fcs_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  logic [7:0] frm [0:255];
  int         frm_n;
  logic [7:0] got [0:511];
  int         got_n, eof_cnt, sof_cnt, ready_leak, hold_err;
  bit         got_eof, prev_stall, stall_on;
  logic [7:0] prev_data;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // back-pressure pattern, driven away from the edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_on ? lfsr[0] : 1'b1;
  end

  // output monitor, mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && out_data !== prev_data) hold_err++;
      if (prev_stall && !out_valid) hold_err++;
      prev_stall = out_valid && !out_ready && (got_n >= frm_n);
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        got[got_n] = out_data;
        if (out_sof) sof_cnt++;
        if (got_n >= frm_n && in_ready) ready_leak++;
        if (out_eof) begin eof_cnt++; got_eof = 1'b1; end
        got_n++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  function automatic logic [31:0] ref_fcs(input logic [7:0] b [0:511], input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] r;
    for (int j = 0; j < n; j++) begin
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[31] ^ b[j][i];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    c = ~c;
    for (int k = 0; k < 32; k++) r[k] = c[31-k];
    return r;
  endfunction

  task automatic make_frame(int n, int seed, logic [15:0] lt);
    frm_n = n;
    for (int i = 0; i < n; i++) frm[i] = 8'((i * 7 + seed * 13 + 1) & 8'hFF);
    if (n > 13) begin frm[12] = lt[15:8]; frm[13] = lt[7:0]; end
  endtask

  task automatic run_frame(bit en, bit toggle, bit stall);
    bit acc;
    got_n = 0; eof_cnt = 0; sof_cnt = 0; ready_leak = 0; hold_err = 0;
    got_eof = 1'b0; prev_stall = 1'b0; stall_on = stall;
    @(posedge clk); #1;
    fcs_en = en;
    for (int i = 0; i < frm_n; i++) begin
      in_valid = 1'b1; in_data = frm[i];
      in_sof = (i == 0); in_eof = (i == frm_n - 1);
      do begin
        @(negedge clk); acc = in_ready;
        @(posedge clk); #1;
      end while (!acc);
      if (toggle && i == 0) fcs_en = !en;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    while (!got_eof) @(posedge clk);
    repeat (3) @(posedge clk);
    #1; stall_on = 1'b0; fcs_en = 1'b1;
  endtask

  task automatic check_frame(bit en, string req);
    logic [7:0] e [0:511];
    int en_len, tgt;
    logic [31:0] f;
    int bad_at;
    en_len = frm_n;
    for (int i = 0; i < frm_n; i++) e[i] = frm[i];
    tgt = en ? 60 : 64;
    while (en_len < tgt) begin e[en_len] = 8'h00; en_len++; end
    if (en) begin
      f = ref_fcs(e, en_len);
      for (int k = 0; k < 4; k++) e[en_len + k] = f[8*k +: 8];
      en_len += 4;
    end
    check(got_n == en_len, req, "frame length", got_n, en_len);
    bad_at = -1;
    for (int i = 0; i < en_len && i < got_n; i++)
      if (bad_at < 0 && got[i] !== e[i]) bad_at = i;
    check(bad_at < 0, req, "byte content (R1 data, R5 fcs)",
          bad_at < 0 ? 0 : int'(got[bad_at]), bad_at < 0 ? 0 : int'(e[bad_at]));
    check(eof_cnt == 1 && sof_cnt == 1, "R7", "single sof/eof", eof_cnt * 10 + sof_cnt, 11);
    check(ready_leak == 0, "R7", "in_ready high during tail", ready_leak, 0);
    check(hold_err == 0, "R9", "tail byte moved under stall", hold_err, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    check(in_ready == out_ready, "R10", "in_ready follows out_ready", in_ready, out_ready);
  endtask

  task automatic t_short_fcs();   // R3 R5
    make_frame(14, 1, 16'h0800); run_frame(1, 0, 0); check_frame(1, "R3");
    make_frame(1, 2, 16'h0000);  run_frame(1, 0, 0); check_frame(1, "R3");
    make_frame(59, 3, 16'h0800); run_frame(1, 0, 0); check_frame(1, "R3");
  endtask

  task automatic t_no_pad();      // R4 R5
    make_frame(60, 4, 16'h86DD);  run_frame(1, 0, 0); check_frame(1, "R4");
    make_frame(200, 5, 16'h0800); run_frame(1, 0, 0); check_frame(1, "R5");
  endtask

  task automatic t_fcs_off();     // R6
    make_frame(20, 6, 16'h0800); run_frame(0, 0, 0); check_frame(0, "R6");
    make_frame(63, 7, 16'h0800); run_frame(0, 0, 0); check_frame(0, "R6");
    make_frame(64, 8, 16'h0800); run_frame(0, 0, 0); check_frame(0, "R6");
    make_frame(90, 9, 16'h0800); run_frame(0, 0, 0); check_frame(0, "R6");
  endtask

  task automatic t_len_field();   // R2
    make_frame(18, 10, 16'h05DC); run_frame(1, 0, 0); check_frame(1, "R2");
    check(got[12] == 8'h05 && got[13] == 8'hDC, "R2", "length value bytes",
          {got[12], got[13]}, 16'h05DC);
    make_frame(30, 11, 16'h0600); run_frame(1, 0, 0);
    check(got[12] == 8'h06 && got[13] == 8'h00, "R2", "type value bytes",
          {got[12], got[13]}, 16'h0600);
  endtask

  task automatic t_mid_toggle();  // R8
    make_frame(30, 12, 16'h0800); run_frame(1, 1, 0); check_frame(1, "R8");
    make_frame(30, 13, 16'h0800); run_frame(0, 1, 0); check_frame(0, "R8");
  endtask

  task automatic t_stall();       // R9
    make_frame(40, 14, 16'h0800); run_frame(1, 0, 1); check_frame(1, "R9");
    make_frame(10, 15, 16'h0800); run_frame(0, 0, 1); check_frame(0, "R9");
    make_frame(3, 16, 16'h0000);  run_frame(1, 0, 1); check_frame(1, "R9");
  endtask

  initial begin
    stall_on = 1'b0; got_n = 0; frm_n = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_short_fcs();
    t_no_pad();
    t_fcs_off();
    t_len_field();
    t_mid_toggle();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule